// File: doc/BRIEF.md
# Serial Driver-Chain Loader

This block is a host-side sequencer for a string of cascaded serial-in, latched output drivers, each eight channels wide. A parallel word of `8 x NUM_DEVICES` bits is handed over on a valid/ready handshake. The loader puts the word on a single data line with a shift clock, sending the most significant bit first. That bit ends up in the device farthest down the chain. After the last clock it waits out a clock-to-latch gap and then pulses the latch line. It marks the end of each update with a one-cycle done pulse.

Each interval is given in nanoseconds as a parameter and converted to whole system-clock cycles, always rounding up. The sequence therefore never undercuts a minimum setup, hold, pulse-width or gap time. Each update also selects a transparent mode. In that mode the latch line is held high permanently, so the drivers follow the shift register directly. To hide the rippling pattern, the output-blanking line is held high for the whole shift phase and released afterwards.

Top module: `drv_chain_loader`

## Requirements
- R1: A word is taken only in a cycle where `valid_i` and `ready_o` are both high. `ready_o` is high only while idle and is low from the cycle after acceptance until the cycle after the done pulse.
- R2: Each update makes exactly `8*NUM_DEVICES` rising edges on `ser_clk_o`. The bits are sent most significant first, so after the update a chain sampling `ser_data_o` on rising edges holds the accepted word, with word bit 15 (default size) in the farthest position.
- R3: `ser_data_o` is stable for at least ceil(T_SETUP_NS/SYS_CLK_NS) cycles before each rising clock edge. It stays unchanged for at least ceil(T_HOLD_NS/SYS_CLK_NS) cycles after the edge and throughout the clock-high time.
- R4: Each high time and each low time of `ser_clk_o` lasts at least ceil(T_CLK_HI_NS/SYS_CLK_NS) and ceil(T_CLK_LO_NS/SYS_CLK_NS) cycles respectively.
- R5: In latched mode, at least ceil(T_GAP_NS/SYS_CLK_NS) cycles pass from the last falling edge of `ser_clk_o` to the rise of `latch_o`, and `latch_o` is never high while `ser_clk_o` is high.
- R6: In latched mode, `latch_o` is high for exactly ceil(T_STB_NS/SYS_CLK_NS) cycles per update.
- R7: In transparent mode (`transparent_i` = 1 at acceptance), `latch_o` stays high, `blank_o` is high at every rising shift edge of the update, and `blank_o` is low once the update is done.
- R8: In latched mode (`transparent_i` = 0 at acceptance), `blank_o` stays low.
- R9: `done_o` is high for exactly one cycle per update. In latched mode that cycle is the first one in which `latch_o` is low again.
- R10: While reset is held, `ready_o` is 1 and `ser_clk_o`, `ser_data_o`, `latch_o`, `blank_o` and `done_o` are 0.
- R11: `valid_i`, `word_i` and `transparent_i` have no effect while an update is in progress. No extra clock edges appear, and the chain ends with the word that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | A new word is offered |
| ready_o | output | 1 | Loader is idle and takes a word |
| word_i | input | 8*NUM_DEVICES | Word to load, MSB for the farthest device |
| transparent_i | input | 1 | 1: latch held open and outputs blanked while shifting |
| ser_data_o | output | 1 | Serial data to the first device |
| ser_clk_o | output | 1 | Shift clock, data taken on its rising edge |
| latch_o | output | 1 | Latch strobe, active high |
| blank_o | output | 1 | Output blanking, high turns driver outputs off |
| done_o | output | 1 | One-cycle pulse at the end of an update |

## Verification
The hardest conditions to reach from the ports are a new offer arriving while an update is under way and a change of mode between two consecutive updates. The second matters because the latch line then falls at acceptance, not at the end of a strobe. To reach the first, the stimulus holds `valid_i` high with an inverted word and the opposite mode for the whole transfer. To reach the second, the vector table alternates latched and transparent entries. A port-level monitor measures every edge spacing in cycles and models the chain and its latches, so each timing minimum and the shifted contents are judged from the pins alone.

// File: rtl/drv_chain_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the driver-chain loader.
// Assumes all time values are non-negative integers in nanoseconds.
package drv_chain_pkg;

    // Phases of one update sequence.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH,
        PH_GAP,
        PH_STB,
        PH_DONE
    } phase_e;

    // Round a time up to whole clock cycles, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                              input int unsigned per_ns);
        int unsigned c;
        c = (t_ns + per_ns - 1) / per_ns;
        return (c == 0) ? 1 : c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drv_chain_timer.sv
`timescale 1ns/1ps
// Phase timer: loads a count and runs down to zero.
// A phase loaded with N-1 lasts N cycles; expired_o is high in its last cycle.
module drv_chain_timer #(
    parameter int unsigned TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_q;

    // Count down toward zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/drv_chain_shifter.sv
`timescale 1ns/1ps
// Parallel-in, serial-out register with a remaining-bit counter.
// The MSB is the serial output and is a flop, so the data line cannot glitch.
// Assumes W >= 2.
module drv_chain_shifter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] word_i,
    output logic         msb_o,
    output logic         last_o
);

    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] left_q;

    // Capture the word, then move it one place toward the MSB per shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= word_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    // Track how many bits are still to be clocked out, current one included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= CW'(W);
        end else if (shift_i && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign msb_o  = sh_q[W-1];
    assign last_o = (left_q == CW'(1));

endmodule

// File: rtl/drv_chain_loader.sv
`timescale 1ns/1ps
// Driver-chain loader: serialises an 8*NUM_DEVICES word MSB first onto a
// data/clock pair, waits a clock-to-latch gap, pulses the latch and signals done.
// Every interval is rounded up to whole SYS_CLK_NS cycles. The setup time is
// folded into the low phase, the hold time into the high phase.
// All control outputs are registered from the next-state decode: no extra
// latency and no decode glitches on the pins.
module drv_chain_loader
    import drv_chain_pkg::*;
#(
    parameter int unsigned NUM_DEVICES  = 2,
    parameter int unsigned SYS_CLK_NS   = 5,
    parameter int unsigned T_SETUP_NS   = 75,
    parameter int unsigned T_HOLD_NS    = 75,
    parameter int unsigned T_CLK_HI_NS  = 150,
    parameter int unsigned T_CLK_LO_NS  = 150,
    parameter int unsigned T_BIT_NS     = 150,
    parameter int unsigned T_GAP_NS     = 300,
    parameter int unsigned T_STB_NS     = 100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       valid_i,
    output logic                       ready_o,
    input  logic [8*NUM_DEVICES-1:0]   word_i,
    input  logic                       transparent_i,
    output logic                       ser_data_o,
    output logic                       ser_clk_o,
    output logic                       latch_o,
    output logic                       blank_o,
    output logic                       done_o
);

    localparam int unsigned W        = 8 * NUM_DEVICES;
    localparam int unsigned HI_CYC   = max_u(ns_to_cyc(T_CLK_HI_NS, SYS_CLK_NS),
                                             ns_to_cyc(T_HOLD_NS, SYS_CLK_NS));
    localparam int unsigned LO_BASE  = max_u(ns_to_cyc(T_CLK_LO_NS, SYS_CLK_NS),
                                             ns_to_cyc(T_SETUP_NS, SYS_CLK_NS));
    localparam int unsigned BIT_CYC  = ns_to_cyc(T_BIT_NS, SYS_CLK_NS);
    localparam int unsigned LO_CYC   = (BIT_CYC > HI_CYC + LO_BASE) ? (BIT_CYC - HI_CYC)
                                                                    : LO_BASE;
    localparam int unsigned GAP_CYC  = ns_to_cyc(T_GAP_NS, SYS_CLK_NS);
    localparam int unsigned STB_CYC  = ns_to_cyc(T_STB_NS, SYS_CLK_NS);
    localparam int unsigned MAX_CYC  = max_u(max_u(LO_CYC, HI_CYC), max_u(GAP_CYC, STB_CYC));
    localparam int unsigned TW       = $clog2(MAX_CYC + 1);

    phase_e          phase_q, phase_d;
    logic            mode_q, mode_d;
    logic            accept, shift;
    logic            tmr_load, tmr_zero, last_bit;
    logic [TW-1:0]   tmr_val;
    logic            ready_q, sclk_q, latch_q, blank_q, done_q;

    drv_chain_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_zero)
    );

    drv_chain_shifter #(.W(W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .shift_i (shift),
        .word_i  (word_i),
        .msb_o   (ser_data_o),
        .last_o  (last_bit)
    );

    // Sequence the phases and arm the timer on every phase entry.
    always_comb begin
        phase_d  = phase_q;
        accept   = 1'b0;
        shift    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_IDLE: begin
                if (valid_i) begin
                    accept   = 1'b1;
                    phase_d  = PH_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LO_CYC - 1);
                end
            end
            PH_LOW: begin
                if (tmr_zero) begin
                    phase_d  = PH_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HI_CYC - 1);
                end
            end
            PH_HIGH: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (last_bit) begin
                        phase_d = PH_GAP;
                        tmr_val = TW'(GAP_CYC - 1);
                    end else begin
                        phase_d = PH_LOW;
                        shift   = 1'b1;
                        tmr_val = TW'(LO_CYC - 1);
                    end
                end
            end
            PH_GAP: begin
                if (tmr_zero) begin
                    phase_d  = PH_STB;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(STB_CYC - 1);
                end
            end
            PH_STB: begin
                if (tmr_zero) begin
                    phase_d = PH_DONE;
                end
            end
            PH_DONE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Mode is captured with the word and held for the whole update.
    assign mode_d = accept ? transparent_i : mode_q;

    // Phase and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            mode_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            mode_q  <= mode_d;
        end
    end

    // Registered pin decode from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
            sclk_q  <= 1'b0;
            latch_q <= 1'b0;
            blank_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            ready_q <= (phase_d == PH_IDLE);
            sclk_q  <= (phase_d == PH_HIGH);
            latch_q <= mode_d || (phase_d == PH_STB);
            blank_q <= mode_d && ((phase_d == PH_LOW) || (phase_d == PH_HIGH));
            done_q  <= (phase_d == PH_DONE);
        end
    end

    assign ready_o   = ready_q;
    assign ser_clk_o = sclk_q;
    assign latch_o   = latch_q;
    assign blank_o   = blank_q;
    assign done_o    = done_q;

endmodule

// File: rtl/drv_chain_loader_chk.sv
`timescale 1ns/1ps
// Protocol checker for drv_chain_loader, bound to every instance of it.
// It observes the pins plus the captured mode register.
module drv_chain_loader_chk #(
    parameter int unsigned HI_CYC  = 30,
    parameter int unsigned STB_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic valid_i,
    input logic ready_o,
    input logic ser_data_o,
    input logic ser_clk_o,
    input logic latch_o,
    input logic blank_o,
    input logic done_o,
    input logic mode_q
);

    logic [31:0] hi_run_q;
    logic [31:0] stb_run_q;

    // Length of the current clock-high and latch-high runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q  <= '0;
            stb_run_q <= '0;
        end else begin
            hi_run_q  <= ser_clk_o ? hi_run_q + 1 : '0;
            stb_run_q <= latch_o ? stb_run_q + 1 : '0;
        end
    end

    assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> !ready_o);

    assert_busy_while_clocking_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_o |-> !ready_o);

    assert_data_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));

    assert_clk_high_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk_o) |-> (hi_run_q >= HI_CYC));

    assert_latch_clk_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && ser_clk_o) |-> !latch_o);

    assert_latch_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !$past(mode_q) && $fell(latch_o)) |-> (stb_run_q == STB_CYC));

    assert_transparent_latch_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> latch_o);

    assert_no_blank_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> mode_q);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && ready_o));

endmodule

bind drv_chain_loader drv_chain_loader_chk #(
    .HI_CYC  (HI_CYC),
    .STB_CYC (STB_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .ready_o    (ready_o),
    .ser_data_o (ser_data_o),
    .ser_clk_o  (ser_clk_o),
    .latch_o    (latch_o),
    .blank_o    (blank_o),
    .done_o     (done_o),
    .mode_q     (mode_q)
);

// File: tb/drv_chain_loader_test.sv
`timescale 1ns/1ps
// Bench: table of words and modes, then directed reset and busy-offer tests.
// A negedge monitor measures pin timing in cycles and models the driver chain.
module drv_chain_loader_test;

    localparam int NDEV  = 2;
    localparam int W     = 8 * NDEV;
    localparam int PER   = 5;
    localparam int SU_C  = (75 + PER - 1) / PER;
    localparam int HO_C  = (75 + PER - 1) / PER;
    localparam int HI_C  = (150 + PER - 1) / PER;
    localparam int LO_C  = (150 + PER - 1) / PER;
    localparam int GAP_C = (300 + PER - 1) / PER;
    localparam int STB_C = (100 + PER - 1) / PER;

    typedef struct packed {
        logic [W-1:0] w;
        logic         m;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'hA5C3, 1'b0},
        '{16'h0000, 1'b0},
        '{16'hFFFF, 1'b1},
        '{16'h8001, 1'b0},
        '{16'h1234, 1'b1},
        '{16'h7FFE, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] word = '0;
    logic         ready, sdata, sclk, latch, blank, done;

    int checks = 0;
    int errors = 0;

    drv_chain_loader #(.NUM_DEVICES(NDEV), .SYS_CLK_NS(PER)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_i       (valid),
        .ready_o       (ready),
        .word_i        (word),
        .transparent_i (mode),
        .ser_data_o    (sdata),
        .ser_clk_o     (sclk),
        .latch_o       (latch),
        .blank_o       (blank),
        .done_o        (done)
    );

    always #2.5 clk = ~clk;

    // Monitor state.
    int cyc = 0, t_change = -1000, t_rise = -1000, t_fall = -1000;
    int t_stb_rise = 0, t_stb_fall = 0, t_done = 0;
    int rises, min_su, min_hi, min_lo, min_hold, gap, stb_w, done_cnt;
    int blank_bad, excl_bad, strb_bad, ready_bad;
    bit hold_pending = 0, busy = 0, cur_mode = 0;
    logic prev_sclk = 0, prev_sdata = 0, prev_latch = 0;
    logic [W-1:0] chain = '0, lat = '0;

    task automatic clear_stats();
        rises = 0; min_su = 1000000; min_hi = 1000000; min_lo = 1000000;
        min_hold = 1000000; gap = -1; stb_w = -1; done_cnt = 0;
        blank_bad = 0; excl_bad = 0; strb_bad = 0; ready_bad = 0;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pin monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (sdata !== prev_sdata) begin
                if (hold_pending && (cyc - t_rise) < min_hold) min_hold = cyc - t_rise;
                hold_pending = 0;
                t_change = cyc;
            end
            if (sclk && !prev_sclk) begin
                rises++;
                if ((cyc - t_change) < min_su) min_su = cyc - t_change;
                if ((cyc - t_fall) < min_lo) min_lo = cyc - t_fall;
                t_rise = cyc;
                hold_pending = 1;
                chain = {chain[W-2:0], sdata};
                if (cur_mode && !blank) blank_bad++;
            end
            if (!sclk && prev_sclk) begin
                if ((cyc - t_rise) < min_hi) min_hi = cyc - t_rise;
                t_fall = cyc;
            end
            if (latch && !prev_latch) begin
                t_stb_rise = cyc;
                gap = cyc - t_fall;
            end
            if (!latch && prev_latch) begin
                stb_w = cyc - t_stb_rise;
                t_stb_fall = cyc;
            end
            if (latch) lat = chain;
            if (done) begin
                done_cnt++;
                t_done = cyc;
            end
            if (busy && ready) ready_bad++;
            if (!cur_mode && blank) blank_bad++;
            if (!cur_mode && sclk && latch) excl_bad++;
            if (cur_mode && busy && !latch) strb_bad++;
            prev_sclk  = sclk;
            prev_sdata = sdata;
            prev_latch = latch;
        end
    end

    // Offer one word, optionally keep offering junk while busy, then check.
    task automatic send(input logic [W-1:0] w, input logic m, input bit disturb);
        while (!ready) begin
            @(posedge clk); #1;
        end
        clear_stats();
        cur_mode = m;
        word = w; mode = m; valid = 1'b1;
        @(posedge clk); #1;
        busy = 1;
        chk(ready == 1'b0, "R1", "ready after accept", int'(ready), 0);
        if (disturb) begin
            word = ~w; mode = ~m; valid = 1'b1;
        end else begin
            valid = 1'b0;
        end
        while (done_cnt == 0) begin
            @(posedge clk); #1;
        end
        busy = 0;
        valid = 1'b0;
        chk(ready == 1'b1, "R1", "ready after done", int'(ready), 1);
        chk(ready_bad == 0, "R1", "ready high while busy", ready_bad, 0);
        chk(rises == W, disturb ? "R11" : "R2", "shift edges", rises, W);
        chk(chain == w, disturb ? "R11" : "R2", "chain content", int'(chain), int'(w));
        chk(lat == w, "R2", "latched content", int'(lat), int'(w));
        chk(min_su >= SU_C, "R3", "setup cycles", min_su, SU_C);
        chk(min_hold >= HO_C, "R3", "hold cycles", min_hold, HO_C);
        chk(min_hi >= HI_C, "R4", "clock high cycles", min_hi, HI_C);
        chk(min_lo >= LO_C, "R4", "clock low cycles", min_lo, LO_C);
        chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        if (!m) begin
            chk(gap >= GAP_C, "R5", "clock-to-latch gap", gap, GAP_C);
            chk(excl_bad == 0, "R5", "latch during clock high", excl_bad, 0);
            chk(stb_w == STB_C, "R6", "latch width", stb_w, STB_C);
            chk(blank_bad == 0, "R8", "blank in latched mode", blank_bad, 0);
            chk(t_done == t_stb_fall, "R9", "done vs latch fall", t_done, t_stb_fall);
        end else begin
            chk(strb_bad == 0, "R7", "latch dropped", strb_bad, 0);
            chk(blank_bad == 0, "R7", "shift edge unblanked", blank_bad, 0);
            repeat (2) @(posedge clk);
            #1;
            chk(blank == 1'b0, "R7", "blank after update", int'(blank), 0);
            chk(latch == 1'b1, "R7", "latch after update", int'(latch), 1);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: values while reset is held.
        chk(ready == 1'b1, "R10", "ready in reset", int'(ready), 1);
        chk(sclk == 1'b0, "R10", "clock in reset", int'(sclk), 0);
        chk(sdata == 1'b0, "R10", "data in reset", int'(sdata), 0);
        chk(latch == 1'b0, "R10", "latch in reset", int'(latch), 0);
        chk(blank == 1'b0, "R10", "blank in reset", int'(blank), 0);
        chk(done == 1'b0, "R10", "done in reset", int'(done), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        for (int i = 0; i < 6; i++) begin
            send(VECS[i].w, VECS[i].m, 1'b0);
        end

        // R11: offers during a latched and a transparent update are ignored.
        send(16'hC35A, 1'b0, 1'b1);
        send(16'h0F0F, 1'b1, 1'b1);
        // Return to latched mode after a transparent update.
        send(16'h6B29, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule